// File: doc/BRIEF.md
# Serial Transmitter with Disable-Time Line Override

This block is an asynchronous serial transmitter. Bytes written into a small transmit queue are sent on a single output line, one frame each. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and a high stop bit. Each bit lasts a fixed number of baud ticks, and the ticks come from an external rate generator as a single-cycle strobe.

A transmit enable selects who owns the line. While the enable is high, the shift engine drives the pin. While it is low, two override bits drive the pin: one sets whether the pin is driven and one sets the level it is driven to. Software sets both override bits high before it enables transmission, so the line rests at mark. Dropping the enable stops a frame at once, clears the queue and returns the engine to idle. If the override level is low at that moment, the pin goes straight to a continuous break.

Two flags support flow control. A low-water flag is raised when the queue level is at or below a programmable threshold and is cleared by any accepted write. A transmit-end flag is high whenever the shift engine is idle and the queue is empty.

Top module: `serial_tx_port`

## Requirements
- R1: While `tx_en` is 0, `txd_oe` equals `port_oe` and `txd_o` equals `port_dat` in the same cycle; with both override bits at 1 the pin is driven high.
- R2: While `tx_en` is 1, `txd_oe` is 1, and the line is high whenever the engine is idle.
- R3: A frame is start (0), then 8 data bits least significant first, then optional parity, then stop (1). Each bit lasts 16 `baud_tick` pulses, whatever the tick spacing in clock cycles.
- R4: `par_mode` encoding: 2'b00 and 2'b11 give no parity bit. 2'b01 gives even parity, so the parity bit is the XOR of the data. 2'b10 gives odd parity, so the parity bit is the inverted XOR. The mode is captured when a byte is loaded.
- R5: When `tx_en` falls, the pin follows the override bits in that same cycle. By the next clock edge the engine is idle and `fifo_level` is 0. A write offered while `tx_en` is 0 is discarded, including one offered in the very cycle the enable falls.
- R6: With `port_oe`=1 and `port_dat`=0, dropping `tx_en` in the middle of a frame drives `txd_o` to a continuous 0.
- R7: After `tx_en` rises again, the line sits at mark and no part of the aborted frame or of the flushed bytes is ever sent.
- R8: When another byte is queued at the end of a stop bit, the next start bit begins right after it, so consecutive start bits are exactly one frame length apart.
- R9: The queue holds 4 bytes. A write while `fifo_full` is 1 is discarded and `fifo_level` stays at 4.
- R10: A write accepted in the same cycle that the engine takes a byte leaves `fifo_level` unchanged.
- R11: `tx_end` is 1 exactly when the engine is idle and the queue is empty. It is 1 after reset and after the stop bit of the last queued frame.
- R12: `fifo_low` is 1 after reset. It clears on the clock edge of an accepted write. It is set again on an edge where no write is accepted and the registered `fifo_level` is at or below `empty_thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit |
| tx_en | input | 1 | Transmit enable; 0 aborts, flushes and hands the pin to the override bits |
| port_oe | input | 1 | Override drive enable used while `tx_en` is 0 |
| port_dat | input | 1 | Override line level used while `tx_en` is 0 |
| par_mode | input | 2 | Parity selection (see R4) |
| wr_valid | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| empty_thresh | input | 3 | Low-water threshold for `fifo_low` |
| txd_o | output | 1 | Serial line level |
| txd_oe | output | 1 | Serial line drive enable; 0 means tri-stated |
| fifo_level | output | 3 | Bytes waiting in the queue |
| fifo_full | output | 1 | Queue holds 4 bytes |
| fifo_low | output | 1 | Sticky low-water flag (see R12) |
| tx_end | output | 1 | Engine idle and queue empty |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a queue write and the engine's pop of a byte. The bench provokes it by writing two bytes on back-to-back cycles into an idle, empty transmitter, so the second write meets the pop of the first. A level of 1 afterwards is the only correct result. The second pair is a write and the fall of the enable. The bench offers a byte in the very cycle the enable drops and expects a level of 0 and a silent line after re-enabling. The same sequence also checks that consecutive start bits are exactly one frame apart, and that the low-water flag stays clear while a byte waits above a zero threshold.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          wr_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [DW-1:0] mem_q [DEPTH];
  logic          rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);
  assign wr_ok = wr_en & ~flush & ~full;
  assign rd_ok = rd_en & ~flush & ~empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (wr_ok) wp_d = bump(wp_q);
      if (rd_ok) rp_d = bump(rp_q);
      lvl_d = lvl_q + LW'(wr_ok) - LW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= wr_data;
  end

  assign rd_data = mem_q[rp_q];
  assign level   = lvl_q;

  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en && !flush |=> $stable(lvl_q));
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && rd_ok |=> $stable(lvl_q));
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import serial_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic [1:0]    par_mode,
  input  logic          have_data,
  input  logic [DW-1:0] data,
  output logic          pop,
  output logic          line,
  output logic          idle
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  tx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          par_q, par_d, paren_q, paren_d;
  logic          bit_end, load;

  assign bit_end = tick && (cnt_q == CW'(OVS - 1));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    par_d   = par_q;
    paren_d = paren_q;
    load    = 1'b0;

    if (st_q != ST_IDLE && tick) cnt_d = bit_end ? '0 : cnt_q + 1'b1;

    unique case (st_q)
      ST_IDLE:  load = have_data;
      ST_START: if (bit_end) begin
                  st_d  = ST_DATA;
                  bit_d = '0;
                end
      ST_DATA:  if (bit_end) begin
                  sh_d = sh_q >> 1;
                  if (bit_q == BW'(DW - 1)) st_d = paren_q ? ST_PAR : ST_STOP;
                  else                      bit_d = bit_q + 1'b1;
                end
      ST_PAR:   if (bit_end) st_d = ST_STOP;
      ST_STOP:  if (bit_end) begin
                  if (have_data) load = 1'b1;
                  else           st_d = ST_IDLE;
                end
      default:  st_d = ST_IDLE;
    endcase

    if (load) begin
      st_d    = ST_START;
      cnt_d   = '0;
      sh_d    = data;
      paren_d = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
      par_d   = (par_mode == PAR_ODD) ? ~^data : ^data;
    end

    if (!enable) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      load  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      paren_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      paren_q <= paren_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign pop  = load;
  assign idle = (st_q == ST_IDLE);

  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> idle);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (st_q == ST_START) && (cnt_q == '0) && !line);
  p_tick_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !tick && !idle && !pop |=> $stable(cnt_q) && $stable(st_q));
endmodule

// File: rtl/tx_pin_mux.sv
module tx_pin_mux (
  input  logic enable,
  input  logic port_oe,
  input  logic port_dat,
  input  logic line,
  output logic txd,
  output logic txd_oe
);
  always_comb begin
    if (enable) begin
      txd    = line;
      txd_oe = 1'b1;
    end else begin
      txd    = port_dat;
      txd_oe = port_oe;
    end
  end
endmodule

// File: rtl/serial_tx_port.sv
module serial_tx_port #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int OVS   = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          tx_en,
  input  logic          port_oe,
  input  logic          port_dat,
  input  logic [1:0]    par_mode,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic [LW-1:0] empty_thresh,
  output logic          txd_o,
  output logic          txd_oe,
  output logic [LW-1:0] fifo_level,
  output logic          fifo_full,
  output logic          fifo_low,
  output logic          tx_end
);
  logic          rst_s_n;
  logic [DW-1:0] head;
  logic          empty, pop, line, idle, wr_ok;
  logic          low_q, low_d;

  rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .flush   (~tx_en),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (head),
    .level   (fifo_level),
    .full    (fifo_full),
    .empty   (empty),
    .wr_ok   (wr_ok)
  );

  tx_shifter #(.DW(DW), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .enable    (tx_en),
    .tick      (baud_tick),
    .par_mode  (par_mode),
    .have_data (~empty),
    .data      (head),
    .pop       (pop),
    .line      (line),
    .idle      (idle)
  );

  tx_pin_mux u_mux (
    .enable   (tx_en),
    .port_oe  (port_oe),
    .port_dat (port_dat),
    .line     (line),
    .txd      (txd_o),
    .txd_oe   (txd_oe)
  );

  always_comb begin
    low_d = low_q;
    if (wr_ok)                          low_d = 1'b0;
    else if (fifo_level <= empty_thresh) low_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) low_q <= 1'b1;
    else          low_q <= low_d;
  end

  assign fifo_low = low_q;
  assign tx_end   = idle & empty;

  p_fall_flush_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(tx_en) |=> (fifo_level == '0) && tx_end);
  p_low_clear_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_valid && tx_en && !fifo_full |=> !fifo_low);
  p_break_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !tx_en && port_oe && !port_dat |-> txd_oe && !txd_o);
  p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_en && tx_end |-> txd_o && txd_oe);
endmodule

// File: tb/serial_tx_port_test.sv
module serial_tx_port_test;
  logic       clk = 1'b0;
  logic       rst_n, baud_tick, tx_en, port_oe, port_dat, wr_valid;
  logic [1:0] par_mode;
  logic [7:0] wr_data;
  logic [2:0] empty_thresh, fifo_level;
  logic       txd_o, txd_oe, fifo_full, fifo_low, tx_end;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  int  div    = 1;
  int  tcnt   = 0;
  bit  done   = 1'b0;

  // {tick divider, parity mode, data}
  localparam logic [11:0] VECS [6] = '{
    {2'd1, 2'b00, 8'hA5}, {2'd1, 2'b01, 8'h3C}, {2'd1, 2'b10, 8'h01},
    {2'd2, 2'b01, 8'h80}, {2'd2, 2'b10, 8'hFF}, {2'd1, 2'b11, 8'h00}};

  serial_tx_port uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .port_oe(port_oe), .port_dat(port_dat), .par_mode(par_mode),
    .wr_valid(wr_valid), .wr_data(wr_data), .empty_thresh(empty_thresh),
    .txd_o(txd_o), .txd_oe(txd_oe), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .fifo_low(fifo_low), .tx_end(tx_end));

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (tcnt >= div - 1) begin baud_tick = 1'b1; tcnt = 0; end
    else                 begin baud_tick = 1'b0; tcnt++;  end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic check_frame(input logic [7:0] d, input logic [1:0] m,
                             input int dv, output int t0);
    logic [10:0] e, got;
    int n, w;
    e = '0; got = '0;
    for (int i = 0; i < 8; i++) e[1+i] = d[i];
    if (m == 2'b01)      begin e[9] = ^d;  e[10] = 1'b1; n = 11; end
    else if (m == 2'b10) begin e[9] = ~^d; e[10] = 1'b1; n = 11; end
    else                 begin e[9] = 1'b1; n = 10; end
    w = 0;
    while (txd_o !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    t0 = cyc;
    if (w >= 4000) begin
      chk(1'b0, "R3 start bit seen", 0, 1);
      return;
    end
    repeat (8 * dv) @(negedge clk);
    got[0] = txd_o;
    for (int i = 1; i < n; i++) begin
      repeat (16 * dv) @(negedge clk);
      got[i] = txd_o;
    end
    chk(got == e, "R3/R4 frame bits", int'(got), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int ta, tb2, tdummy;
    rst_n = 1'b0; tx_en = 1'b0; port_oe = 1'b0; port_dat = 1'b0;
    par_mode = 2'b00; wr_valid = 1'b0; wr_data = '0; empty_thresh = 3'd0;
    baud_tick = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk(txd_oe == 1'b0, "R1 tri-state after reset", txd_oe, 0);
    chk(tx_end == 1'b1, "R11 tx_end after reset", tx_end, 1);
    chk(fifo_low == 1'b1, "R12 fifo_low after reset", fifo_low, 1);
    chk(fifo_level == 3'd0, "R9 level after reset", fifo_level, 0);

    // Override drives mark before enabling
    port_oe = 1'b1; port_dat = 1'b1; #1;
    chk(txd_oe && txd_o, "R1 mark from override", {txd_oe, txd_o}, 3);
    @(negedge clk);
    push(8'h55);
    chk(fifo_level == 3'd0, "R5 write ignored while disabled", fifo_level, 0);

    tx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(txd_oe && txd_o, "R2 idle mark when enabled", {txd_oe, txd_o}, 3);

    // Vector table
    foreach (VECS[k]) begin
      div      = int'(VECS[k][11:10]);
      par_mode = VECS[k][9:8];
      @(negedge clk);
      push(VECS[k][7:0]);
      check_frame(VECS[k][7:0], VECS[k][9:8], div, tdummy);
      repeat (8 * div + 2) @(negedge clk);
      chk(tx_end == 1'b1 && txd_o == 1'b1, "R11 tx_end after last frame",
          {tx_end, txd_o}, 3);
    end
    div = 1; par_mode = 2'b00;
    repeat (4) @(negedge clk);

    // Write in the pop cycle; back-to-back frames; low-water with threshold 0
    empty_thresh = 3'd0;
    push(8'h96);
    push(8'h4B);
    chk(fifo_level == 3'd1, "R10 write during pop keeps level", fifo_level, 1);
    chk(fifo_low == 1'b0, "R12 fifo_low clear above threshold", fifo_low, 0);
    check_frame(8'h96, 2'b00, 1, ta);
    check_frame(8'h4B, 2'b00, 1, tb2);
    chk(tb2 - ta == 160, "R8 start-to-start spacing", tb2 - ta, 160);
    chk(fifo_low == 1'b1, "R12 fifo_low set at threshold", fifo_low, 1);
    repeat (12) @(negedge clk);

    // Low-water with threshold 2: clear on write, set on next edge
    empty_thresh = 3'd2;
    push(8'hC3);
    chk(fifo_low == 1'b0, "R12 cleared by write", fifo_low, 0);
    @(negedge clk);
    chk(fifo_low == 1'b1, "R12 re-set at level under threshold", fifo_low, 1);
    check_frame(8'hC3, 2'b00, 1, tdummy);
    repeat (12) @(negedge clk);

    // Overfill during a frame
    push(8'h0F);
    while (txd_o !== 1'b0) @(negedge clk);
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    chk(fifo_level == 3'd4 && fifo_full, "R9 full stops at depth",
        {fifo_full, fifo_level}, 12);
    repeat (40) @(negedge clk);

    // Abort mid-frame into a break
    port_dat = 1'b0;
    tx_en    = 1'b0; #1;
    chk(txd_oe && !txd_o, "R6 break drives low at once", {txd_oe, txd_o}, 2);
    @(negedge clk);
    chk(fifo_level == 3'd0 && tx_end, "R5 flush and idle after abort",
        {tx_end, fifo_level}, 8);
    begin
      int highs = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd_o !== 1'b0) highs++; end
      chk(highs == 0, "R6 continuous break", highs, 0);
    end

    // Re-enable: mark only, nothing left over
    port_dat = 1'b1;
    tx_en    = 1'b1;
    begin
      int lows = 0;
      for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd_o !== 1'b1) lows++; end
      chk(lows == 0, "R7 no residual frame after re-enable", lows, 0);
    end

    // Write offered in the cycle the enable falls
    wr_valid = 1'b1; wr_data = 8'hE7; tx_en = 1'b0;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(fifo_level == 3'd0, "R5 write lost when enable falls", fifo_level, 0);
    tx_en = 1'b1;
    begin
      int lows = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd_o !== 1'b1) lows++; end
      chk(lows == 0, "R7 line stays at mark", lows, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule